// File: doc/BRIEF.md
# Two-Port-on-One-Array RAM Wrapper

This block is a memory with a separate read port and a separate write port that share one clock. It is built to map onto a single-port array that is accessed twice in every cycle: first for the read and then for the write. In any cycle the caller can stay idle, read, write, or read and write together. Read data comes out combinationally in the same cycle as the read enable. When the read enable is low, the output keeps the last word that was read.

A power-control side models the low-power behaviour of the array. An eight-bit sleep bus, a retention flag and a stand-by input can be tied to zero for normal operation. Sleep blocks all access. Sleep without retention also loses the stored contents. Stand-by blocks access but keeps the contents. Depth and word width are parameters, and the depth does not have to be a power of two.

Top module: `pdpram_wrap`

## Requirements
- R1: After the synchronous active-high reset, `rd_data` is zero, and every word reads as zero until it is written.
- R2: With `rd_en` high and the array awake, `rd_data` shows the addressed word in that same cycle.
- R3: With `rd_en` low, `rd_data` keeps the value of the last completed read. This holds even if that word is overwritten in the meantime.
- R4: A write with `wr_en` high takes effect at the rising edge, so a read of that address in the next cycle returns the written data.
- R5: When a read and a write target the same address in one cycle, the read returns the contents from before that write.
- R6: A write to an address at or above DEPTH changes no word. A read of such an address returns zero.
- R7: While any bit of `sleep_ctl` is 1, `rd_data` is zero and writes are ignored.
- R8: A sleep period with `retain` held high leaves the stored contents intact after wake-up.
- R9: Any cycle asleep with `retain` low invalidates all words. Each word then reads as zero until it is written again.
- R10: While `standby` is high, `rd_data` is zero, writes are ignored, and the contents survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read enable |
| rd_addr | input | AW | Read address |
| rd_data | output | WIDTH | Read data, same cycle as the read, held when idle |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write address |
| wr_data | input | WIDTH | Write data, valid with `wr_en` |
| sleep_ctl | input | 8 | Array power-gate controls; any bit set puts the array to sleep |
| retain | input | 1 | Keep the contents through sleep |
| standby | input | 1 | Stand-by: blocks access, keeps the contents |

## Verification
The data path is driven with the four operation kinds in isolation, and then with a long random mix that forces frequent same-address pairs, against a reference array.

- Isolated reads and writes separate the same-cycle read path from the edge-timed write path.
- A same-address read-plus-write shows whether the read is ordered before the write or after it.
- An idle read enable during a write to the held word tells a true output hold apart from a live view of the array.
- Out-of-range writes followed by reads of the word below them expose address aliasing.
- Sleep with retention and sleep without retention are each followed by reads that separate kept contents from lost contents.
- Stand-by is checked separately, to show that it blocks access without losing the contents.

// File: rtl/pdpram_pkg.sv
package pdpram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_RD   = 2'b01,
        OP_WR   = 2'b10,
        OP_RDWR = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic gated;   // no access this cycle
        logic wipe;    // contents lost this cycle
    } pwr_state_t;

    function automatic pwr_state_t decode_power(input logic [7:0] sleep,
                                                input logic retain,
                                                input logic standby);
        pwr_state_t p;
        p.gated = (|sleep) | standby;
        p.wipe  = (|sleep) & ~retain;
        return p;
    endfunction

    function automatic op_kind_e classify(input logic re, input logic we,
                                          input logic gated);
        if (gated) return OP_IDLE;
        return op_kind_e'({we, re});
    endfunction

endpackage

// File: rtl/pdpram_power.sv
module pdpram_power
    import pdpram_pkg::*;
(
    input  logic [7:0] sleep_ctl,
    input  logic       retain,
    input  logic       standby,
    input  logic       rd_en,
    input  logic       wr_en,
    output logic       gated,
    output logic       wipe,
    output op_kind_e   op
);
    pwr_state_t pst;

    always_comb begin
        pst   = decode_power(sleep_ctl, retain, standby);
        gated = pst.gated;
        wipe  = pst.wipe;
        op    = classify(rd_en, wr_en, pst.gated);
    end
endmodule

// File: rtl/pdpram_store.sv
module pdpram_store #(
    parameter int DEPTH = 48,
    parameter int WIDTH = 32,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic             wr_fire,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic             wr_in_range;
    logic             rd_in_range;

    assign wr_in_range = (int'(wr_addr) < DEPTH);
    assign rd_in_range = (int'(rd_addr) < DEPTH);

    // Array content: no reset; validity is tracked separately.
    always_ff @(posedge clk) begin
        if (wr_fire && wr_in_range)
            mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || wipe)
            valid_q <= '0;
        else if (wr_fire && wr_in_range)
            valid_q[wr_addr] <= 1'b1;
    end

    // Read sees the pre-edge contents: first half of the double-pumped cycle.
    always_comb begin
        rd_word = '0;
        if (rd_in_range && valid_q[rd_addr])
            rd_word = mem[rd_addr];
    end
endmodule

// File: rtl/pdpram_rdhold.sv
module pdpram_rdhold #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gated,
    input  logic             rd_fire,
    input  logic [WIDTH-1:0] rd_word,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (rd_fire)
            hold_q <= rd_word;
    end

    always_comb begin
        if (gated)
            rd_data = '0;
        else if (rd_fire)
            rd_data = rd_word;
        else
            rd_data = hold_q;
    end
endmodule

// File: rtl/pdpram_wrap.sv
module pdpram_wrap
    import pdpram_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int WIDTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [7:0]       sleep_ctl,
    input  logic             retain,
    input  logic             standby
);
    logic             gated;
    logic             wipe;
    op_kind_e         op;
    logic             rd_fire;
    logic             wr_fire;
    logic [WIDTH-1:0] rd_word;

    pdpram_power u_power (
        .sleep_ctl (sleep_ctl),
        .retain    (retain),
        .standby   (standby),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .gated     (gated),
        .wipe      (wipe),
        .op        (op)
    );

    assign rd_fire = (op == OP_RD) || (op == OP_RDWR);
    assign wr_fire = (op == OP_WR) || (op == OP_RDWR);

    pdpram_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wipe    (wipe),
        .wr_fire (wr_fire),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    pdpram_rdhold #(.WIDTH(WIDTH)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .gated   (gated),
        .rd_fire (rd_fire),
        .rd_word (rd_word),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/pdpram_wrap_chk.sv
module pdpram_wrap_chk #(
    parameter int DEPTH = 48,
    parameter int WIDTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic [AW-1:0]    rd_addr,
    input logic [WIDTH-1:0] rd_data,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [WIDTH-1:0] wr_data,
    input logic [7:0]       sleep_ctl,
    input logic             retain,
    input logic             standby
);
    logic asleep;
    logic wr_ok;
    assign asleep = (|sleep_ctl) | standby;
    assign wr_ok  = wr_en && !asleep && (int'(wr_addr) < DEPTH);

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !asleep && !rd_en && !$past(asleep) && !$past(rd_en))
        |-> rd_data == $past(rd_data)); // R3

    AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_ok) && !asleep && rd_en && rd_addr == $past(wr_addr))
        |-> rd_data == $past(wr_data)); // R4

    AST_COLLISION_OLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_ok) && !asleep && rd_en && wr_en
         && rd_addr == wr_addr && rd_addr == $past(wr_addr) && wr_data != $past(wr_data))
        |-> rd_data != wr_data); // R5

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!asleep && rd_en && int'(rd_addr) >= DEPTH) |-> rd_data == '0); // R6

    AST_ASLEEP_ZERO: assert property (@(posedge clk) disable iff (rst)
        asleep |-> rd_data == '0); // R7
endmodule

bind pdpram_wrap pdpram_wrap_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/pdpram_wrap_test.sv
module pdpram_wrap_test;
    localparam int DEPTH = 48;
    localparam int WIDTH = 32;
    localparam int AW    = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst;
    logic             rd_en, wr_en;
    logic [AW-1:0]    rd_addr, wr_addr;
    logic [WIDTH-1:0] wr_data, rd_data;
    logic [7:0]       sleep_ctl;
    logic             retain, standby;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [WIDTH-1:0] ref_mem [DEPTH];
    logic [DEPTH-1:0] ref_val;
    logic [WIDTH-1:0] ref_hold;

    always #2 clk = ~clk;

    pdpram_wrap #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sleep_ctl(sleep_ctl), .retain(retain), .standby(standby)
    );

    task automatic check(input string req, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive after negedge, check same-cycle output, update model at posedge.
    task automatic op(input string req, input logic re, input int ra,
                      input logic we, input int wa, input logic [WIDTH-1:0] wd);
        logic [WIDTH-1:0] exp;
        logic gated;
        rd_en = re; rd_addr = AW'(ra); wr_en = we; wr_addr = AW'(wa); wr_data = wd;
        #1;
        gated = (|sleep_ctl) | standby;
        if (gated) exp = '0;
        else if (re) exp = (ra < DEPTH && ref_val[ra]) ? ref_mem[ra] : '0;
        else exp = ref_hold;
        check(req, rd_data, exp);
        @(posedge clk);
        if (!gated) begin
            if (re) ref_hold = exp;
            if (we && wa < DEPTH) begin ref_mem[wa] = wd; ref_val[wa] = 1'b1; end
        end
        if ((|sleep_ctl) && !retain) ref_val = '0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; rd_en = 0; wr_en = 0; rd_addr = '0; wr_addr = '0; wr_data = '0;
        sleep_ctl = '0; retain = 0; standby = 0;
        ref_val = '0; ref_hold = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 check("R1 idle after reset", rd_data, '0);
        @(negedge clk);
        for (int a = 0; a < DEPTH; a += 7) op("R1 unwritten word", 1, a, 0, 0, '0);
    endtask

    task automatic t_basic;
        op("R2 write only", 0, 0, 1, 5, 32'hA5A5_0005);
        op("R4 next-cycle read", 1, 5, 0, 0, '0);
        op("R4 write last word", 0, 0, 1, DEPTH-1, 32'hDEAD_BEEF);
        op("R2 read last word", 1, DEPTH-1, 1, 9, 32'h0000_0909);
        op("R2 read other addr", 1, 9, 0, 0, '0);
    endtask

    task automatic t_hold;
        op("R3 read to latch", 1, 5, 0, 0, '0);
        op("R3 hold while writing held word", 0, 0, 1, 5, 32'h1111_2222);
        op("R3 still held", 0, 0, 0, 0, '0);
        op("R4 new data visible", 1, 5, 0, 0, '0);
    endtask

    task automatic t_collision;
        op("R5 seed", 0, 0, 1, 12, 32'hC0C0_0001);
        op("R5 collide returns old", 1, 12, 1, 12, 32'hC0C0_0002);
        op("R5 after collide new", 1, 12, 1, 12, 32'hC0C0_0003);
        op("R5 settled", 1, 12, 0, 0, '0);
    endtask

    task automatic t_oor;
        op("R6 seed low word", 0, 0, 1, 2, 32'h2222_0002);
        op("R6 write above depth", 0, 0, 1, 50, 32'hBAD0_0050);
        op("R6 no alias", 1, 2, 0, 0, '0);
        op("R6 read above depth", 1, 50, 0, 0, '0);
        op("R6 read top addr", 1, (1 << AW) - 1, 0, 0, '0);
    endtask

    task automatic t_sleep_keep;
        op("R8 seed", 0, 0, 1, 20, 32'h2020_2020);
        sleep_ctl = 8'h10; retain = 1;
        op("R7 sleeping read zero", 1, 20, 1, 20, 32'hFFFF_FFFF);
        op("R7 sleeping write ignored", 1, 5, 1, 21, 32'h2121_2121);
        sleep_ctl = '0;
        op("R8 kept after sleep", 1, 20, 0, 0, '0);
        op("R7 write dropped during sleep", 1, 21, 0, 0, '0);
        retain = 0;
    endtask

    task automatic t_sleep_lose;
        op("R9 seed", 0, 0, 1, 30, 32'h3030_3030);
        sleep_ctl = 8'h01; retain = 0;
        op("R9 sleeping", 0, 0, 0, 0, '0);
        sleep_ctl = '0;
        op("R9 lost after wake", 1, 30, 0, 0, '0);
        op("R9 lost other word", 1, 20, 1, 30, 32'h3131_3131);
        op("R9 rewritten valid", 1, 30, 0, 0, '0);
    endtask

    task automatic t_standby;
        op("R10 seed", 0, 0, 1, 40, 32'h4040_4040);
        standby = 1;
        op("R10 standby read zero", 1, 40, 1, 40, 32'h9999_9999);
        standby = 0;
        op("R10 contents kept", 1, 40, 0, 0, '0);
    endtask

    task automatic t_mixed;
        for (int i = 0; i < 400; i++) begin
            int ra = $urandom_range(DEPTH - 1);
            int wa = ($urandom_range(3) == 0) ? ra : $urandom_range(DEPTH - 1);
            op("R5 random mix", 1'($urandom_range(1)), ra, 1'($urandom_range(1)), wa, $urandom);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_hold();
        t_collision();
        t_oor();
        t_sleep_keep();
        t_sleep_lose();
        t_standby();
        t_mixed();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule